// File: doc/BRIEF.md
# I2C Repeated-Start Sequencer with Arbitration Check

This block produces the repeated-start condition for an I2C bus master and watches the open-drain lines while doing so, in case another master is competing for the bus. On an accepted request it first lets SDA float high while it keeps SCL held low. It then lets SCL go and waits for SCL to be seen high. After that it holds both lines released for one timed interval, pulls SDA low, and after one more interval holds SCL low. Each interval comes from a down-counting divider that is loaded from a 7-bit reload value. If the reload value is zero, an interval lasts one cycle.

Two kinds of interference are detected. In the first, SDA is already low when SCL is first seen rising, which means another master is sending a 0. In the second, SCL drops during the released interval before this block has pulled SDA low, which means another master is sending a 1. On either event a sticky collision flag is set, both lines are released and the sequencer returns to idle. A successful sequence sets a sticky completion flag and leaves both lines pulled low for the transfer that follows. Software clears each flag with its own pulse. Both bus inputs pass through a two-flop synchronizer before they are used.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset `sda_pull`, `scl_pull`, `busy`, `coll_flag` and `done_flag` are all 0.
- R2: After an accepted `start_req`, `busy` is 1 and the block releases SDA (`sda_pull`=0) while holding SCL (`scl_pull`=1) for max(N,1) cycles, where N is `reload_val`.
- R3: The block then releases both lines and waits, with no time limit and no collision, until the synchronized SCL goes from low to high. Clock stretching by another device therefore only lengthens the wait. When nothing holds SCL, the wait lasts 3 cycles.
- R4: If the synchronized SDA is low at that SCL rise, a collision is detected.
- R5: If SDA is high at the rise, both lines stay released for max(N,1) more cycles. A synchronized SCL low during this interval is a collision.
- R6: SDA falling during that interval is not a collision, and the sequence continues.
- R7: The block then pulls SDA low with SCL released for max(N,1) cycles. After that it pulls SCL low, sets `done_flag` and drops `busy`, and both pulls stay at 1 while idle.
- R8: On a collision, `coll_flag` is set, both pulls go to 0, `busy` drops and the sequencer goes idle.
- R9: `coll_flag` and `done_flag` stay set until a one-cycle pulse on `clr_coll` or `clr_done` respectively clears them.
- R10: `start_req` is ignored while `busy` is 1 or while `coll_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to begin a repeated start |
| reload_val | input | 7 | Interval length in cycles (0 acts as 1) |
| sda_in | input | 1 | Sensed SDA line level |
| scl_in | input | 1 | Sensed SCL line level |
| clr_coll | input | 1 | Pulse that clears the collision flag |
| clr_done | input | 1 | Pulse that clears the completion flag |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| coll_flag | output | 1 | Sticky bus-collision flag |
| done_flag | output | 1 | Sticky repeated-start-complete flag |

## Verification
The assertions assume the clear pulses are never raised in the same cycle as an event that sets the same flag. They also assume `reload_val` is held steady while the sequencer is busy. The bench keeps within both: it pulses a clear only while the block is idle, and it changes the reload value only between sequences. The line model forms each wire as the AND of the block's release and a second master's release, so every line level seen at the inputs is one that a real open-drain bus could show.

// File: rtl/rstart_pkg.sv
package rstart_pkg;

    parameter int RELOAD_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SDA_REL,
        ST_SCL_REL,
        ST_HOLD,
        ST_SDA_LOW
    } seq_state_t;

    typedef struct packed {
        logic sda;
        logic scl;
    } bus_pair_t;

    function automatic logic [RELOAD_W-1:0] eff_count(input logic [RELOAD_W-1:0] r);
        return (r == '0) ? RELOAD_W'(1) : r;
    endfunction

endpackage

// File: rtl/rstart_sync.sv
module rstart_sync #(
    parameter int NLINES = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] d,
    output logic [NLINES-1:0] q
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '1;
            else     sh <= {sh[STAGES-2:0], d[i]};
        end
        assign q[i] = sh[STAGES-1];
    end
endmodule

// File: rtl/rstart_brg.sv
module rstart_brg
    import rstart_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expired
);
    logic [RELOAD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= eff_count(reload);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == RELOAD_W'(1));

    // R5: the count never stalls above zero without a reload
    p_cnt_moves_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt != $past(cnt)));
endmodule

// File: rtl/rstart_fsm.sv
module rstart_fsm
    import rstart_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_req,
    input  logic      clr_coll,
    input  logic      clr_done,
    input  bus_pair_t lines_s,
    input  logic      expired,
    output logic      load,
    output bus_pair_t drive,
    output logic      busy,
    output logic      coll_flag,
    output logic      done_flag
);
    seq_state_t state, state_nx;
    logic park_low;
    logic scl_prev;
    logic scl_rise;
    logic set_coll, set_done;

    assign scl_rise = lines_s.scl && !scl_prev;

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        set_coll = 1'b0;
        set_done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_req && !coll_flag) begin
                    state_nx = ST_SDA_REL;
                    load     = 1'b1;
                end
            end
            ST_SDA_REL: begin
                if (expired) state_nx = ST_SCL_REL;
            end
            ST_SCL_REL: begin
                if (scl_rise) begin
                    if (!lines_s.sda) begin
                        set_coll = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        load     = 1'b1;
                        state_nx = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (!lines_s.scl) begin
                    set_coll = 1'b1;
                    state_nx = ST_IDLE;
                end else if (expired) begin
                    load     = 1'b1;
                    state_nx = ST_SDA_LOW;
                end
            end
            ST_SDA_LOW: begin
                if (expired) begin
                    set_done = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            park_low  <= 1'b0;
            scl_prev  <= 1'b1;
            coll_flag <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            state    <= state_nx;
            scl_prev <= lines_s.scl;
            if (set_done)      park_low <= 1'b1;
            else if (set_coll) park_low <= 1'b0;
            if (set_coll)      coll_flag <= 1'b1;
            else if (clr_coll) coll_flag <= 1'b0;
            if (set_done)      done_flag <= 1'b1;
            else if (clr_done) done_flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (state)
            ST_SDA_REL: drive = '{sda: 1'b0, scl: 1'b1};
            ST_SCL_REL: drive = '{sda: 1'b0, scl: 1'b0};
            ST_HOLD:    drive = '{sda: 1'b0, scl: 1'b0};
            ST_SDA_LOW: drive = '{sda: 1'b1, scl: 1'b0};
            default:    drive = '{sda: park_low, scl: park_low};
        endcase
    end

    assign busy = (state != ST_IDLE);

    // R8: a new collision leaves both lines released and the sequencer idle
    p_coll_release_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(coll_flag) |-> (!drive.sda && !drive.scl && !busy));
    // R7: completion leaves both lines pulled low
    p_done_parks_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> (drive.sda && drive.scl && !busy));
    // R7: during a sequence the block never holds both lines at once
    p_single_pull_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(drive.sda && drive.scl));
    // R5: SCL low while both lines are released in the hold interval is a collision
    p_hold_scl_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !lines_s.scl) |=> coll_flag);
    // R9: flags stay set until cleared
    p_coll_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (coll_flag && !clr_coll) |=> coll_flag);
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !clr_done) |=> done_flag);
    // R10: a request is not taken while the collision flag is set
    p_no_start_coll_r10: assert property (@(posedge clk) disable iff (rst)
        (coll_flag && !busy) |=> !busy);
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen
    import rstart_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_req,
    input  logic [RELOAD_W-1:0] reload_val,
    input  logic                sda_in,
    input  logic                scl_in,
    input  logic                clr_coll,
    input  logic                clr_done,
    output logic                sda_pull,
    output logic                scl_pull,
    output logic                busy,
    output logic                coll_flag,
    output logic                done_flag
);
    logic [1:0] lines_raw, lines_q;
    bus_pair_t  lines_s, drive;
    logic       load, expired;

    assign lines_raw = {sda_in, scl_in};

    rstart_sync #(.NLINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(lines_raw), .q(lines_q)
    );

    assign lines_s = bus_pair_t'(lines_q);

    rstart_brg u_brg (
        .clk(clk), .rst(rst), .load(load), .reload(reload_val), .expired(expired)
    );

    rstart_fsm u_fsm (
        .clk(clk), .rst(rst), .start_req(start_req),
        .clr_coll(clr_coll), .clr_done(clr_done),
        .lines_s(lines_s), .expired(expired), .load(load),
        .drive(drive), .busy(busy),
        .coll_flag(coll_flag), .done_flag(done_flag)
    );

    assign sda_pull = drive.sda;
    assign scl_pull = drive.scl;
endmodule

// File: tb/tb_i2c_rstart_gen.sv
`timescale 1ns/1ps
module tb_i2c_rstart_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0;
    logic [6:0] reload_val = 7'd3;
    logic clr_coll = 1'b0, clr_done = 1'b0;
    logic other_sda = 1'b0, other_scl = 1'b0;
    logic sda_in, scl_in;
    logic sda_pull, scl_pull, busy, coll_flag, done_flag;

    int n_checks = 0;
    int n_fail = 0;
    int ca = 0, cb = 0, cc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign sda_in = !(sda_pull || other_sda);
    assign scl_in = !(scl_pull || other_scl);

    i2c_rstart_gen dut (
        .clk(clk), .rst(rst), .start_req(start_req), .reload_val(reload_val),
        .sda_in(sda_in), .scl_in(scl_in), .clr_coll(clr_coll), .clr_done(clr_done),
        .sda_pull(sda_pull), .scl_pull(scl_pull), .busy(busy),
        .coll_flag(coll_flag), .done_flag(done_flag)
    );

    always @(negedge clk) begin
        if (busy && !sda_pull && scl_pull)  ca++;
        if (busy && !sda_pull && !scl_pull) cb++;
        if (busy && sda_pull && !scl_pull)  cc++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int n);
        @(negedge clk);
        ca = 0; cb = 0; cc = 0;
        reload_val = 7'(n);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic clear_flags;
        @(negedge clk);
        clr_coll = 1'b1; clr_done = 1'b1;
        @(negedge clk);
        clr_coll = 1'b0; clr_done = 1'b0;
    endtask

    task automatic t_reset;
        check(!sda_pull && !scl_pull, "R1 pulls", {sda_pull, scl_pull}, 0);
        check(!busy && !coll_flag && !done_flag, "R1 status", {busy, coll_flag, done_flag}, 0);
    endtask

    task automatic t_normal(input int n, input bit poke);
        int e = (n == 0) ? 1 : n;
        pulse_start(n);
        check(busy, "R2 busy after start", busy, 1);
        if (poke) begin
            while (!(busy && sda_pull)) @(negedge clk);
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        wait_idle(400);
        check(ca == e, "R2 SDA release phase", ca, e);
        check(cb == e + 3, "R3/R5 released phase", cb, e + 3);
        check(cc == e, "R7 SDA low phase", cc, e);
        check(done_flag && !coll_flag, "R7 done set", {done_flag, coll_flag}, 2);
        check(sda_pull && scl_pull, "R7 lines parked low", {sda_pull, scl_pull}, 3);
        repeat (4) @(negedge clk);
        check(!busy, "R10 no rerun after poke", busy, 0);
        check(done_flag, "R9 done sticky", done_flag, 1);
        clear_flags();
        check(!done_flag, "R9 done cleared", done_flag, 0);
    endtask

    task automatic t_coll_sda;
        other_sda = 1'b1;
        pulse_start(4);
        wait_idle(200);
        check(coll_flag && !done_flag, "R4 SDA-low collision", {coll_flag, done_flag}, 2);
        check(!sda_pull && !scl_pull && !busy, "R8 released on collision", {sda_pull, scl_pull, busy}, 0);
        check(cc == 0, "R4 no SDA low phase", cc, 0);
        other_sda = 1'b0;
        pulse_start(2);
        for (int i = 0; i < 5; i++) begin
            check(!busy && !scl_pull, "R10 start ignored with collision", {busy, scl_pull}, 0);
            @(negedge clk);
        end
        check(coll_flag, "R9 coll sticky", coll_flag, 1);
        clear_flags();
        check(!coll_flag, "R9 coll cleared", coll_flag, 0);
    endtask

    task automatic t_coll_scl;
        pulse_start(20);
        while (cb < 6) @(negedge clk);
        other_scl = 1'b1;
        wait_idle(20);
        check(coll_flag && !done_flag, "R5 SCL-low collision", {coll_flag, done_flag}, 2);
        check(!sda_pull && !scl_pull && !busy, "R8 released on SCL collision", {sda_pull, scl_pull, busy}, 0);
        other_scl = 1'b0;
        clear_flags();
    endtask

    task automatic t_sda_fall;
        pulse_start(20);
        while (cb < 6) @(negedge clk);
        other_sda = 1'b1;
        wait_idle(200);
        check(done_flag && !coll_flag, "R6 SDA fall tolerated", {done_flag, coll_flag}, 2);
        check(cc == 20, "R6 SDA low phase ran", cc, 20);
        other_sda = 1'b0;
        clear_flags();
    endtask

    task automatic t_stretch;
        other_scl = 1'b1;
        pulse_start(2);
        repeat (30) @(negedge clk);
        check(busy && !coll_flag, "R3 waits while SCL held", {busy, coll_flag}, 2);
        check(!sda_pull && !scl_pull, "R3 both released while waiting", {sda_pull, scl_pull}, 0);
        other_scl = 1'b0;
        wait_idle(200);
        check(done_flag && !coll_flag, "R3 completes after stretch", {done_flag, coll_flag}, 2);
        clear_flags();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal(3, 1'b0);
        t_normal(0, 1'b0);
        t_normal(5, 1'b1);
        t_coll_sda();
        t_coll_scl();
        t_sda_fall();
        t_stretch();
        t_normal(1, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule